// File: doc/BRIEF.md
# Dual-Width Virtual Machine Arithmetic Unit

This block carries out the arithmetic and logic instructions of a small packet-filter virtual machine. It takes an 8-bit opcode, a 64-bit destination operand, a 64-bit source register value and a 32-bit immediate. It returns the result, a write-enable for the register file and a flag that marks an unusable operation code. One decoder serves two instruction classes. One class works on the low 32-bit half of each register and zero-fills the upper half of the result. The other class works on full 64-bit operands.

The datapath between the opcode and the result is combinational. The three outputs are registered, so a result appears one clock after its inputs are presented. The surrounding pipeline owns the register file, the memory accesses and the control flow. It takes the result and writes it back whenever the write-enable is high.

Top module: `valu_unit`

## Requirements
- R1: The opcode is split into three fields: operation = bits 7:4, source select = bit 3, class = bits 2:0. Class 3'h4 selects the 32-bit mode and class 3'h7 selects the 64-bit mode. Any other class gives write-enable 0, illegal 0 and result 0.
- R2: When bit 3 is 1, the source operand is the source register value. When bit 3 is 0, the source operand is the immediate. In 64-bit mode the immediate is sign-extended from bit 31.
- R3: In 32-bit mode every operation except byte-order conversion is computed on bits 31:0 of both operands, and the result is zero-extended so that bits 63:32 are 0.
- R4: The following operation codes apply: 0x0 add, 0x1 subtract, 0x2 multiply (low bits kept), 0x4 OR, 0x5 AND, 0xa XOR, 0xb move (the result is the source operand) and 0x8 negate (the result is 0 minus the destination; the source operand is not used).
- R5: The shift operations are 0x6 left, 0x7 logical right (fills with zeros) and 0xc arithmetic right (fills with the operand's sign bit). The shift amount is the source operand masked to 5 bits in 32-bit mode and to 6 bits in 64-bit mode.
- R6: Code 0x3 is unsigned divide and gives 0 when the divisor is 0. Code 0x9 is unsigned remainder. When its divisor is 0 it returns the destination operand, cut to the mode's width.
- R7: Code 0xd is byte-order conversion on the full 64-bit destination in either class. An immediate of 16 selects width 16, an immediate of 32 selects width 32, and any other value selects width 64. With bit 3 = 1, the low bytes of that width are reversed. With bit 3 = 0, they are passed through unchanged. Bits above the width are 0 in both cases.
- R8: Operation codes 0xe and 0xf in either ALU class give illegal 1, write-enable 0 and result 0.
- R9: The outputs are registered with a latency of one clock. A synchronous active-high reset clears the result, the write-enable and the illegal flag. Every legal ALU opcode gives write-enable 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 8 | Instruction opcode |
| dst_i | input | 64 | Destination operand value |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Registered write-enable |
| illegal_o | output | 1 | Registered illegal-opcode flag |

## Verification
The assertions check on every cycle that the illegal flag never comes together with a write and always comes with a zero result. They also check that non-ALU classes stay quiet, that 32-bit results have an empty upper half, that a 64-bit register move copies its source, that a 64-bit divide by zero gives zero, and that reset clears the outputs. Only the bench scenarios can show the value of each operation: shift masking, sign filling, unsigned divide and remainder, the three widths of byte-order conversion, and the sign extension of immediates. The bench compares mixed random and directed vectors against an independent model.

// File: rtl/valu_pkg.sv
package valu_pkg;
  localparam logic [2:0] CLS_W32 = 3'h4;
  localparam logic [2:0] CLS_W64 = 3'h7;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_DIV  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_SHL  = 4'h6;
  localparam logic [3:0] OP_SHR  = 4'h7;
  localparam logic [3:0] OP_NEG  = 4'h8;
  localparam logic [3:0] OP_REM  = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'ha;
  localparam logic [3:0] OP_MOV  = 4'hb;
  localparam logic [3:0] OP_SAR  = 4'hc;
  localparam logic [3:0] OP_BORD = 4'hd;

  typedef enum logic [1:0] {
    BW_16 = 2'd0,
    BW_32 = 2'd1,
    BW_64 = 2'd2
  } bord_width_e;
endpackage

// File: rtl/valu_decode.sv
module valu_decode
  import valu_pkg::*;
(
  input  logic [7:0] opcode,
  output logic [3:0] op,
  output logic       use_reg,
  output logic       w32,
  output logic       is_alu,
  output logic       illegal
);
  logic [2:0] cls;

  always_comb begin
    cls     = opcode[2:0];
    op      = opcode[7:4];
    use_reg = opcode[3];
    w32     = (cls == CLS_W32);
    is_alu  = (cls == CLS_W32) || (cls == CLS_W64);
    illegal = is_alu && (opcode[7:5] == 3'b111);
  end
endmodule

// File: rtl/valu_bswap.sv
module valu_bswap
  import valu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] v,
  input  bord_width_e       wsel,
  input  logic              swap,
  output logic [DATA_W-1:0] y
);
  localparam int NB   = DATA_W / 8;
  localparam int NB32 = 4;
  localparam int NB16 = 2;

  logic [DATA_W-1:0] sw_full, sw_32, sw_16;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_full
      assign sw_full[8*gi +: 8] = v[8*(NB-1-gi) +: 8];
    end
    for (gi = 0; gi < NB; gi++) begin : g_w32
      if (gi < NB32) begin : g_in
        assign sw_32[8*gi +: 8] = v[8*(NB32-1-gi) +: 8];
      end else begin : g_out
        assign sw_32[8*gi +: 8] = 8'h00;
      end
    end
    for (gi = 0; gi < NB; gi++) begin : g_w16
      if (gi < NB16) begin : g_in
        assign sw_16[8*gi +: 8] = v[8*(NB16-1-gi) +: 8];
      end else begin : g_out
        assign sw_16[8*gi +: 8] = 8'h00;
      end
    end
  endgenerate

  always_comb begin
    case (wsel)
      BW_16:   y = swap ? sw_16 : {{(DATA_W-16){1'b0}}, v[15:0]};
      BW_32:   y = swap ? sw_32 : {{(DATA_W-32){1'b0}}, v[31:0]};
      default: y = swap ? sw_full : v;
    endcase
  end
endmodule

// File: rtl/valu_core.sv
module valu_core
  import valu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [3:0]        op,
  input  logic              w32,
  input  logic              use_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int H     = DATA_W / 2;
  localparam int SH_W  = $clog2(DATA_W);
  localparam int SHH_W = SH_W - 1;

  logic [H-1:0]      a_lo, b_lo, r_lo;
  logic [DATA_W-1:0] r_full, bord_y;
  logic [SH_W-1:0]   sh_full;
  logic [SHH_W-1:0]  sh_lo;
  bord_width_e       bw;

  always_comb begin
    a_lo    = a[H-1:0];
    b_lo    = b[H-1:0];
    sh_full = b[SH_W-1:0];
    sh_lo   = b[SHH_W-1:0];
    if (imm == IMM_W'(16))      bw = BW_16;
    else if (imm == IMM_W'(32)) bw = BW_32;
    else                        bw = BW_64;
  end

  // full-width datapath
  always_comb begin
    case (op)
      OP_ADD:  r_full = a + b;
      OP_SUB:  r_full = a - b;
      OP_MUL:  r_full = a * b;
      OP_DIV:  r_full = (b == '0) ? '0 : a / b;
      OP_OR:   r_full = a | b;
      OP_AND:  r_full = a & b;
      OP_SHL:  r_full = a << sh_full;
      OP_SHR:  r_full = a >> sh_full;
      OP_NEG:  r_full = '0 - a;
      OP_REM:  r_full = (b == '0) ? a : a % b;
      OP_XOR:  r_full = a ^ b;
      OP_MOV:  r_full = b;
      OP_SAR:  r_full = $unsigned($signed(a) >>> sh_full);
      default: r_full = '0;
    endcase
  end

  // half-width datapath for the subregister class
  always_comb begin
    case (op)
      OP_ADD:  r_lo = a_lo + b_lo;
      OP_SUB:  r_lo = a_lo - b_lo;
      OP_MUL:  r_lo = a_lo * b_lo;
      OP_DIV:  r_lo = (b_lo == '0) ? '0 : a_lo / b_lo;
      OP_OR:   r_lo = a_lo | b_lo;
      OP_AND:  r_lo = a_lo & b_lo;
      OP_SHL:  r_lo = a_lo << sh_lo;
      OP_SHR:  r_lo = a_lo >> sh_lo;
      OP_NEG:  r_lo = '0 - a_lo;
      OP_REM:  r_lo = (b_lo == '0) ? a_lo : a_lo % b_lo;
      OP_XOR:  r_lo = a_lo ^ b_lo;
      OP_MOV:  r_lo = b_lo;
      OP_SAR:  r_lo = $unsigned($signed(a_lo) >>> sh_lo);
      default: r_lo = '0;
    endcase
  end

  valu_bswap #(.DATA_W(DATA_W)) u_bswap (
    .v    (a),
    .wsel (bw),
    .swap (use_reg),
    .y    (bord_y)
  );

  always_comb begin
    if (op == OP_BORD) res = bord_y;
    else if (w32)      res = {{H{1'b0}}, r_lo};
    else               res = r_full;
  end
endmodule

// File: rtl/valu_unit.sv
module valu_unit
  import valu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        opcode_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  localparam int H = DATA_W / 2;

  logic [3:0]        op;
  logic              use_reg, w32, is_alu, illegal;
  logic [DATA_W-1:0] operand_b, core_res, res_d;
  logic              we_d;

  valu_decode u_dec (
    .opcode  (opcode_i),
    .op      (op),
    .use_reg (use_reg),
    .w32     (w32),
    .is_alu  (is_alu),
    .illegal (illegal)
  );

  always_comb begin
    if (use_reg) operand_b = src_i;
    else         operand_b = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  end

  valu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .op      (op),
    .w32     (w32),
    .use_reg (use_reg),
    .imm     (imm_i),
    .a       (dst_i),
    .b       (operand_b),
    .res     (core_res)
  );

  always_comb begin
    we_d  = is_alu && !illegal;
    res_d = we_d ? core_res : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= res_d;
      wr_en_o   <= we_d;
      illegal_o <= illegal;
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!wr_en_o && result_o == '0)); // R8

  AST_FOREIGN_CLASS: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode_i[2:0]) != CLS_W32 && $past(opcode_i[2:0]) != CLS_W64)
    |-> (!wr_en_o && !illegal_o)); // R1

  AST_W32_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && $past(opcode_i[2:0]) == CLS_W32 && $past(opcode_i[7:4]) != OP_BORD)
    |-> (result_o[DATA_W-1:H] == '0)); // R3

  AST_MOV_REG64: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode_i) == {OP_MOV, 1'b1, CLS_W64}) |-> (result_o == $past(src_i))); // R4

  AST_DIV_ZERO64: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode_i) == {OP_DIV, 1'b1, CLS_W64} && $past(src_i) == '0)
    |-> (result_o == '0)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !wr_en_o && !illegal_o)); // R9
endmodule

// File: tb/valu_unit_tb.sv
`timescale 1ns/1ps
module valu_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  opcode = 8'h00;
  logic [63:0] dst = '0, src = '0;
  logic [31:0] imm = '0;
  logic [63:0] result;
  logic        wr_en, illegal;

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  valu_unit dut_i (
    .clk(clk), .rst(rst), .opcode_i(opcode), .dst_i(dst), .src_i(src),
    .imm_i(imm), .result_o(result), .wr_en_o(wr_en), .illegal_o(illegal)
  );

  function automatic logic [63:0] rev_bytes(logic [63:0] v, int nbytes);
    logic [63:0] r = '0;
    for (int i = 0; i < nbytes; i++) r[8*i +: 8] = v[8*(nbytes-1-i) +: 8];
    return r;
  endfunction

  // returns {illegal, write-enable, result}
  function automatic logic [65:0] model(logic [7:0] op, logic [63:0] d, logic [63:0] s,
                                        logic [31:0] im);
    logic [2:0]  cls = op[2:0];
    logic [3:0]  n   = op[7:4];
    logic        rsel = op[3];
    logic [63:0] m, a, b, r;
    logic signed [63:0] t;
    int sh, w;
    if (cls != 3'd4 && cls != 3'd7) return '0;
    if (n >= 4'he) return {1'b1, 1'b0, 64'h0};
    m = (cls == 3'd4) ? 64'h0000_0000_FFFF_FFFF : '1;
    a = d & m;
    b = (rsel ? s : {{32{im[31]}}, im}) & m;
    sh = (cls == 3'd4) ? int'(b[4:0]) : int'(b[5:0]);
    case (n)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = (b == 0) ? 64'h0 : a / b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = 64'h0 - a;
      4'h9: r = (b == 0) ? a : a % b;
      4'ha: r = a ^ b;
      4'hb: r = b;
      4'hc: begin
        t = (cls == 3'd4) ? {{32{a[31]}}, a[31:0]} : a;
        r = t >>> sh;
      end
      default: begin
        w = (im == 16) ? 16 : (im == 32) ? 32 : 64;
        if (rsel) r = rev_bytes(d, w / 8);
        else      r = (w == 64) ? d : (d & ((64'h1 << w) - 1));
        return {1'b0, 1'b1, r};
      end
    endcase
    return {1'b0, 1'b1, r & m};
  endfunction

  function automatic string tag_of(logic [7:0] op);
    if (op[2:0] != 3'd4 && op[2:0] != 3'd7) return "R1";
    case (op[7:4])
      4'h6, 4'h7, 4'hc: return "R5";
      4'h3, 4'h9:       return "R6";
      4'hd:             return "R7";
      4'he, 4'hf:       return "R8";
      default:          return "R4";
    endcase
  endfunction

  task automatic run(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                     input logic [31:0] im, input string tag);
    logic [65:0] e;
    opcode = op; dst = d; src = s; imm = im;
    e = model(op, d, s, im);
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if ({illegal, wr_en, result} !== e) begin
      miscmp++;
      $display("FAIL %s op=%h: got ill=%b we=%b res=%h expected ill=%b we=%b res=%h",
               tag, op, illegal, wr_en, result, e[65], e[64], e[63:0]);
    end
  endtask

  function automatic logic [63:0] pick64();
    case ($urandom % 7)
      0: return 64'h0;
      1: return '1;
      2: return 64'h0000_0000_8000_0000;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'($urandom % 70);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // R9: reset holds outputs at zero even with a legal opcode applied
    opcode = 8'h0f; dst = 64'h5; src = 64'h7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (result !== 64'h0 || wr_en !== 1'b0 || illegal !== 1'b0) begin
      miscmp++;
      $display("FAIL R9 reset: got res=%h we=%b ill=%b expected 0 0 0", result, wr_en, illegal);
    end
    rst = 1'b0;

    // R1: foreign class stays quiet
    run(8'h05, 64'h1, 64'h2, 32'h3, "R1");
    // R2: 64-bit negative immediate is sign-extended
    run(8'h07, 64'h10, 64'h0, 32'hFFFF_FFFF, "R2");
    run(8'hb7, 64'h0, 64'h0, 32'h8000_0000, "R2");
    // R3: 32-bit add wraps and zero-extends
    run(8'h0c, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'h0, "R3");
    run(8'hb4, 64'h0, 64'h0, 32'h8000_0000, "R3");
    // R4: negate and register move
    run(8'h87, 64'h1, 64'h0, 32'h0, "R4");
    run(8'hbf, 64'h0, 64'hDEAD_BEEF_0123_4567, 32'h0, "R4");
    // R5: shift masking and sign fill
    run(8'h64, 64'h1, 64'h0, 32'd33, "R5");
    run(8'h67, 64'h1, 64'h0, 32'd65, "R5");
    run(8'hc4, 64'h8000_0000, 64'h0, 32'd4, "R5");
    run(8'hcf, 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R5");
    run(8'h7f, 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R5");
    // R6: unsigned divide and zero divisor cases
    run(8'h3f, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h0, "R6");
    run(8'h9c, 64'h1234_5678_9ABC_DEF0, 64'h0, 32'h0, "R6");
    run(8'h9f, 64'h1234_5678_9ABC_DEF0, 64'h0, 32'h0, "R6");
    run(8'h37, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h2, "R6");
    // R7: byte-order conversion at each width, swap and truncate
    run(8'hdc, 64'h1122_3344_5566_7788, 64'h0, 32'd16, "R7");
    run(8'hdc, 64'h1122_3344_5566_7788, 64'h0, 32'd32, "R7");
    run(8'hdf, 64'h1122_3344_5566_7788, 64'h0, 32'd64, "R7");
    run(8'hd4, 64'h1122_3344_5566_7788, 64'h0, 32'd16, "R7");
    run(8'hd7, 64'h1122_3344_5566_7788, 64'h0, 32'd32, "R7");
    // R8: reserved operation codes
    run(8'he4, 64'h1, 64'h1, 32'h1, "R8");
    run(8'hff, 64'h1, 64'h1, 32'h1, "R8");

    for (int k = 0; k < 3000; k++) begin
      logic [7:0] op;
      logic [2:0] cls;
      int r = $urandom % 8;
      logic [31:0] im;
      cls = (r < 3) ? 3'd4 : (r < 6) ? 3'd7 : 3'($urandom);
      op  = {4'($urandom), 1'($urandom), cls};
      case ($urandom % 4)
        0: im = 32'd16;
        1: im = 32'd32;
        2: im = 32'($urandom % 70);
        default: im = $urandom;
      endcase
      run(op, pick64(), pick64(), im, tag_of(op));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule